// File: doc/BRIEF.md
# Shared Ready/Data Serial Read-Out

This block is the converter-side end of a read-only two-wire serial port. The conversion core hands it a 16-bit result and an out-of-range flag. The block holds them in an output register and signals that a result is waiting by pulling a single shared line low. The host then clocks the word out on that same line with a serial clock. A read is 24 bits: the result comes first, most significant bit first, followed by a status byte. The status byte carries a fixed check pattern and a device identifier, so the host can confirm that the transfer arrived intact.

The serial clock is sampled by the block's internal clock through a synchroniser. The line changes after each falling serial edge. Each result can be read only once. A warning pulse from the core, sent shortly before each register update, withdraws readiness so that a host never reads across an update. A new result always restarts the shift position. The active-low power-down input resets all state and releases the line; in this model the pad driver follows an enable output.

The result strobe is a one-cycle valid pulse with no ready signal, because the conversion core cannot be stalled. A result that arrives while an older one is unread replaces it. The host has no way to push back on the core, so it must finish each read before the next update.

Top module: `ready_data_serializer`

## Requirements
- R1: While `pd_n` is low, `dout_oe` is 0 and all state is cleared. From the first clock edge after `pd_n` rises, `dout_oe` is 1 and `dout` is driven high until the first result is accepted.
- R2: One clock cycle after a `res_valid` pulse, `dout` is low. This signals that an unread word is waiting.
- R3: Each falling `sclk` edge puts the next frame bit on `dout`. Frame bit 23 goes first and bit 0 goes last. Bits 23..8 are `res_data`, with its bit 15 first.
- R4: Frame bits 7..0 are the status byte {ready=0, 0, err, 0, 1, 1, 0, 1}, where err is the `res_err` value captured with the result. This gives 0x0D when err is 0 and 0x2D when err is 1.
- R5: After the rising `sclk` edge that follows the 24th bit, `dout` returns high. It stays high, and further `sclk` edges have no effect, until the next result arrives.
- R6: A `upd_warn` pulse drives `dout` high on the next cycle and discards the unread word. Later `sclk` edges leave `dout` high.
- R7: A new result resets the shift position, even in the middle of a read. The next read starts from bit 23 of the new word.
- R8: A word may be read in several bursts separated by idle `sclk` gaps. The bits read are the same as in a continuous read.
- R9: Falling `sclk` edges while no unread word is present leave `dout` high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Internal clock. It must be at least 4x the `sclk` rate. |
| pd_n | input | 1 | Active-low power-down and asynchronous reset. |
| sclk | input | 1 | Serial clock from the host. It idles high, and its falling edge is the active edge. |
| upd_warn | input | 1 | One-cycle pulse from the core, sent shortly before the next update. |
| res_valid | input | 1 | One-cycle strobe that delivers a new result. |
| res_data | input | 16 | Conversion result. |
| res_err | input | 1 | Set when the input was out of range for this result. |
| dout | output | 1 | Shared ready/data line level. |
| dout_oe | output | 1 | Pad drive enable. When it is 0 the line is tristated. |

## Verification
The assertions assume that `res_valid` and `upd_warn` are single-cycle pulses. They also assume that each `sclk` phase lasts long enough for the synchroniser to report every edge exactly once, and that `pd_n` is the only reset. The stimulus drives every input on the falling `clk` edge, so each input is stable at the sampling edge. It gives each pulse one cycle and holds each `sclk` phase for 104 ns, which is thirteen internal clocks. It reads `dout` just before the next `sclk` transition, which leaves far more time than the three-cycle synchroniser and output-register latency.

// File: rtl/rdo_pkg.sv
package rdo_pkg;
  localparam int RES_W   = 16;
  localparam int STAT_W  = 8;
  localparam int FRAME_W = RES_W + STAT_W;
  localparam int CNT_W   = $clog2(FRAME_W + 1);

  // Fixed fields of the trailing status byte.
  localparam logic [1:0] DEV_ID    = 2'b01;
  localparam logic [2:0] CHECK_PAT = 3'b101;

  // Status byte, most significant bit first on the line:
  // ready flag (0 = available), constant 0, range error, id, check pattern.
  function automatic logic [STAT_W-1:0] status_byte(input logic err);
    return {1'b0, 1'b0, err, DEV_ID, CHECK_PAT};
  endfunction
endpackage

// File: rtl/rdo_sclk_sync.sv
module rdo_sclk_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sclk_in,
  output logic fall,
  output logic rise
);
  logic [STAGES-1:0] chain;
  logic              last;

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain[g] <= 1'b1;
        else if (g == 0) chain[g] <= sclk_in;
        else chain[g] <= chain[(g == 0) ? 0 : g-1];
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) last <= 1'b1;
    else        last <= chain[STAGES-1];
  end

  assign fall = last & ~chain[STAGES-1];
  assign rise = ~last & chain[STAGES-1];

  // R3: a reported falling edge leaves the synchronised level low on the next cycle
  a_r3_fall_level: assert property (@(posedge clk) disable iff (!rst_n)
    fall |=> !last);
endmodule

// File: rtl/rdo_frame_reg.sv
module rdo_frame_reg
  import rdo_pkg::*;
#(
  parameter int RW    = RES_W,
  parameter int FW    = RW + STAT_W,
  parameter int SEL_W = $clog2(FW + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [RW-1:0]    res_data,
  input  logic             res_err,
  input  logic [SEL_W-1:0] sel,
  output logic             frame_bit
);
  logic [FW-1:0] word_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    word_q <= '1;
    else if (load) word_q <= {res_data, status_byte(res_err)};
  end

  always_comb begin
    frame_bit = 1'b1;
    if (sel < SEL_W'(FW)) frame_bit = word_q[sel];
  end

  // R4: fixed id and check fields are present in every stored frame
  a_r4_status_fields: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (word_q[4:0] == 5'b01101) && (word_q[7:6] == 2'b00));
endmodule

// File: rtl/rdo_shift_ctrl.sv
module rdo_shift_ctrl #(
  parameter int FW    = 24,
  parameter int CNT_W = $clog2(FW + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             warn,
  input  logic             fall,
  input  logic             rise,
  input  logic             frame_bit,
  output logic [CNT_W-1:0] cnt,
  output logic             have,
  output logic             line
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(FW);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      have <= 1'b0;
      cnt  <= '0;
      line <= 1'b1;
    end else if (load) begin
      have <= 1'b1;
      cnt  <= '0;
      line <= 1'b0;
    end else if (warn) begin
      have <= 1'b0;
      cnt  <= '0;
      line <= 1'b1;
    end else if (have && fall && (cnt < LAST)) begin
      line <= frame_bit;
      cnt  <= cnt + CNT_W'(1);
    end else if (have && rise && (cnt == LAST)) begin
      have <= 1'b0;
      cnt  <= '0;
      line <= 1'b1;
    end
  end

  // R2: an accepted result shows as ready on the next cycle
  a_r2_load_ready: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (have && !line));
  // R6: warning without a new result drops readiness
  a_r6_warn_drop: assert property (@(posedge clk) disable iff (!rst_n)
    (warn && !load) |=> (!have && line));
  // R5 / R9: with no unread word the line is high
  a_r9_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
    !have |-> line);
  // R3: the bit position never passes the frame length
  a_r3_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= LAST);
  // R5: the rise after the last bit retires the word
  a_r5_retire: assert property (@(posedge clk) disable iff (!rst_n)
    (have && rise && (cnt == LAST) && !load && !warn) |=> !have);
endmodule

// File: rtl/ready_data_serializer.sv
module ready_data_serializer
  import rdo_pkg::*;
#(
  parameter int RW          = RES_W,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          pd_n,
  input  logic          sclk,
  input  logic          upd_warn,
  input  logic          res_valid,
  input  logic [RW-1:0] res_data,
  input  logic          res_err,
  output logic          dout,
  output logic          dout_oe
);
  localparam int FW = RW + STAT_W;
  localparam int CW = $clog2(FW + 1);

  logic          s_fall, s_rise, f_bit, have, line, oe_q;
  logic [CW-1:0] cnt, sel;

  rdo_sclk_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(pd_n), .sclk_in(sclk), .fall(s_fall), .rise(s_rise));

  assign sel = CW'(FW - 1) - cnt;

  rdo_frame_reg #(.RW(RW), .FW(FW), .SEL_W(CW)) u_frame (
    .clk(clk), .rst_n(pd_n), .load(res_valid), .res_data(res_data),
    .res_err(res_err), .sel(sel), .frame_bit(f_bit));

  rdo_shift_ctrl #(.FW(FW), .CNT_W(CW)) u_ctrl (
    .clk(clk), .rst_n(pd_n), .load(res_valid), .warn(upd_warn),
    .fall(s_fall), .rise(s_rise), .frame_bit(f_bit),
    .cnt(cnt), .have(have), .line(line));

  always_ff @(posedge clk or negedge pd_n) begin
    if (!pd_n) oe_q <= 1'b0;
    else       oe_q <= 1'b1;
  end

  assign dout    = line;
  assign dout_oe = oe_q;

  // R1: once driving, the line stays driven until power-down
  a_r1_oe_hold: assert property (@(posedge clk) disable iff (!pd_n)
    dout_oe |=> dout_oe);
  // R1: the line is high while driven without a word
  a_r1_high_no_word: assert property (@(posedge clk) disable iff (!pd_n)
    (dout_oe && !have) |-> dout);
endmodule

// File: tb/ready_data_serializer_tb.sv
module ready_data_serializer_tb;
  logic        clk = 1'b0;
  logic        pd_n = 1'b0;
  logic        sclk = 1'b1;
  logic        upd_warn = 1'b0;
  logic        res_valid = 1'b0;
  logic [15:0] res_data = '0;
  logic        res_err = 1'b0;
  logic        dout, dout_oe;

  int errors = 0;
  int checks = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  ready_data_serializer u_dut (
    .clk(clk), .pd_n(pd_n), .sclk(sclk), .upd_warn(upd_warn),
    .res_valid(res_valid), .res_data(res_data), .res_err(res_err),
    .dout(dout), .dout_oe(dout_oe));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [23:0] frame(input logic [15:0] d, input logic e);
    return {d, 1'b0, 1'b0, e, 2'b01, 3'b101};
  endfunction

  task automatic bit_clk(output logic b);
    sclk = 1'b0;
    #104;
    b = dout;
    sclk = 1'b1;
    #104;
  endtask

  task automatic read_n(input int n, inout logic [23:0] acc);
    for (int i = 0; i < n; i++) begin
      logic b;
      bit_clk(b);
      acc = {acc[22:0], b};
    end
  endtask

  task automatic convert(input logic [15:0] d, input logic e);
    @(negedge clk);
    res_data = d; res_err = e; res_valid = 1'b1;
    @(negedge clk);
    res_valid = 1'b0;
    @(negedge clk);
  endtask

  task automatic warn_pulse();
    @(negedge clk);
    upd_warn = 1'b1;
    @(negedge clk);
    upd_warn = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_reset();
    pd_n = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 oe during power-down", {31'd0, dout_oe}, 32'd0);
    pd_n = 1'b1;
    repeat (2) @(negedge clk);
    chk("R1 oe after release", {31'd0, dout_oe}, 32'd1);
    chk("R1 line high after release", {31'd0, dout}, 32'd1);
  endtask

  task automatic t_idle_edges();
    logic [23:0] acc = '0;
    read_n(3, acc);
    chk("R9 falling edges with no word", {29'd0, acc[2:0]}, 32'h7);
    chk("R9 line after idle edges", {31'd0, dout}, 32'd1);
  endtask

  task automatic t_basic();
    logic [23:0] acc = '0;
    convert(16'hA5C3, 1'b0);
    chk("R2 ready low", {31'd0, dout}, 32'd0);
    read_n(24, acc);
    chk("R3 frame A5C3", {8'd0, acc}, {8'd0, frame(16'hA5C3, 1'b0)});
    chk("R4 status err=0", {24'd0, acc[7:0]}, 32'h0D);
    chk("R5 line high after read", {31'd0, dout}, 32'd1);
    read_n(2, acc);
    chk("R5 extra edges ignored", {30'd0, acc[1:0]}, 32'h3);
  endtask

  task automatic t_err();
    logic [23:0] acc = '0;
    convert(16'h0000, 1'b1);
    read_n(24, acc);
    chk("R4 status err=1", {8'd0, acc}, {8'd0, frame(16'h0000, 1'b1)});
    convert(16'hFFFF, 1'b0);
    read_n(24, acc);
    chk("R3 frame FFFF", {8'd0, acc}, {8'd0, frame(16'hFFFF, 1'b0)});
  endtask

  task automatic t_burst();
    logic [23:0] acc = '0;
    convert(16'h3C96, 1'b1);
    read_n(8, acc);
    #2000;
    read_n(10, acc);
    #1500;
    read_n(6, acc);
    chk("R8 burst read", {8'd0, acc}, {8'd0, frame(16'h3C96, 1'b1)});
    #300;
    chk("R5 high after burst read", {31'd0, dout}, 32'd1);
  endtask

  task automatic t_warn();
    logic [23:0] acc = '0;
    convert(16'h5555, 1'b0);
    warn_pulse();
    chk("R6 warn drops ready", {31'd0, dout}, 32'd1);
    read_n(4, acc);
    chk("R6 word not readable after warn", {28'd0, acc[3:0]}, 32'hF);
  endtask

  task automatic t_restart();
    logic [23:0] acc = '0;
    convert(16'h1234, 1'b0);
    read_n(5, acc);
    warn_pulse();
    convert(16'hBEEF, 1'b1);
    chk("R7 ready after mid-read update", {31'd0, dout}, 32'd0);
    read_n(24, acc);
    chk("R7 read restarts at MSB", {8'd0, acc}, {8'd0, frame(16'hBEEF, 1'b1)});
  endtask

  task automatic t_powerdown();
    logic [23:0] acc = '0;
    convert(16'h0F0F, 1'b0);
    read_n(4, acc);
    @(negedge clk);
    pd_n = 1'b0;
    repeat (2) @(negedge clk);
    chk("R1 tristate mid-read", {31'd0, dout_oe}, 32'd0);
    pd_n = 1'b1;
    repeat (2) @(negedge clk);
    chk("R1 high after mid-read reset", {31'd0, dout}, 32'd1);
    read_n(3, acc);
    chk("R1 no word survives reset", {29'd0, acc[2:0]}, 32'h7);
  endtask

  initial begin
    t_reset();
    t_idle_edges();
    t_basic();
    t_err();
    t_burst();
    t_warn();
    t_restart();
    t_powerdown();
    if (!done) begin
      done = 1'b1;
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    #1000000;
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule